// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static RAM whose data bus never idles when traffic switches between reads and writes. A command (address, direction, byte selects, burst order) is captured on one rising clock edge. The data phase for that command occupies the very next cycle. Write data is captured on the edge that closes the data phase. Read data is flow-through: it is driven combinationally from the array for the whole data cycle, with no output register.

A small control state machine tracks the pending data phase in three states: `PH_IDLE` (nothing pending), `PH_READ` (read data phase) and `PH_WRITE` (write data phase). The transitions are named as follows. LOAD_READ and LOAD_WRITE happen when a selected load command arrives. ADVANCE happens when the advance input keeps a running burst alive, and the state stays the same. DESELECT happens when a load arrives without all three enables, and it returns the machine to `PH_IDLE`. SLEEP_BLOCK happens when the sleep input is high at an edge, and it also returns to `PH_IDLE`. STALL happens when clock enable is inactive, and every register holds. A four-beat burst counter walks the two low address bits in either linear or interleaved order. The bus is split into `din`, `dout` and a `dout_en` output enable.

Top module: `zbt_sram`

## Requirements
- R1: A command sampled on an active edge (cke_n=0) has its data phase in the following cycle. During a read data phase, dout equals the array word at the phase address, and dout_en=1 when oe_n=0 and sleep=0.
- R2: Write data is taken from din on the active edge that ends the write data phase. Each bw_n bit i is active low and gates bits 9*i+8 down to 9*i. Lanes with bw_n[i]=1 keep their old contents.
- R3: While cke_n=1, edges are ignored. The pending phase, the burst position and the array all hold, and the phase is stretched until the next active edge.
- R4: A load (adv_ld=0) starts an operation only when ce1_n=0, ce2=1, ce3_n=0 and sleep=0. rd_wr=1 starts a read and rd_wr=0 starts a write. A load without all three enables leaves no phase pending in the next cycle.
- R5: A pending read or write completes in its data cycle even if the same edge deselects the device.
- R6: dout_en is 0 in the cycle after a deselecting load and in the cycle after a write load.
- R7: oe_n=1 forces dout_en to 0 combinationally, in any cycle.
- R8: adv_ld=1 during an active burst repeats the operation type at the next burst address. The upper address bits are fixed. The low two bits are base+k mod 4 when the burst was loaded with burst_lin=1, or base XOR k when burst_lin=0, and the sequence wraps after four beats. adv_ld=1 with nothing pending keeps the machine idle.
- R9: Write-then-read and read-then-write command streams run on consecutive cycles with no idle cycle. A read directly after a write to the same address returns the new data.
- R10: sleep=1 at an active edge blocks both loads and advances. sleep=1 also holds dout_en at 0.
- R11: After reset, no phase is pending and dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the control state |
| cke_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| rd_wr | input | 1 | 1 read, 0 write |
| bw_n | input | 4 | Byte-lane write selects, active low |
| burst_lin | input | 1 | 1 linear burst order, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Blocks new operations and disables outputs |
| addr | input | ADDR_W | Command address |
| din | input | 36 | Write data |
| dout | output | 36 | Flow-through read data |
| dout_en | output | 1 | Drive enable for dout |

## Verification
A wrong phase state shows up in the same cycle as a wrong `dout_en`, because the output enable depends directly on the pending phase. A wrong burst position or base shows up as a wrong `dout` word in the affected read beat. A misdirected write or a wrong lane mask stays hidden until that address is read again. For that reason the random stream reads all addresses repeatedly, and the directed cases read back a written word in the very next cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/zbt_burst.sv
module zbt_burst #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] base_low,
    input  logic [CNT_W-1:0] beat,
    input  logic             linear,
    output logic [CNT_W-1:0] low
);
    always_comb begin
        if (linear) low = base_low + beat;
        else        low = base_low ^ beat;
    end
endmodule

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic [LANES-1:0]  bw_n,
    input  logic              burst_lin,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    output phase_e            phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  cur_bw_n
);
    localparam int HI_W = ADDR_W - BURST_W;

    phase_e               phase_q, phase_d;
    logic [ADDR_W-1:0]    base_q, base_d;
    logic [BURST_W-1:0]   cnt_q, cnt_d;
    logic                 lin_q, lin_d;
    logic [LANES-1:0]     bw_q, bw_d;
    logic                 selected;
    logic [BURST_W-1:0]   low;

    assign selected = !ce1_n && ce2 && !ce3_n;

    // state register: holds whenever clock enable is inactive (STALL)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            lin_q   <= 1'b0;
            bw_q    <= '1;
        end else if (!cke_n) begin
            phase_q <= phase_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            lin_q   <= lin_d;
            bw_q    <= bw_d;
        end
    end

    // next-state: LOAD_READ, LOAD_WRITE, ADVANCE, DESELECT, SLEEP_BLOCK
    always_comb begin
        phase_d = phase_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        lin_d   = lin_q;
        bw_d    = bw_q;
        if (sleep) begin
            phase_d = PH_IDLE;
        end else if (!adv_ld) begin
            if (selected) begin
                phase_d = rd_wr ? PH_READ : PH_WRITE;
                base_d  = addr;
                cnt_d   = '0;
                lin_d   = burst_lin;
                bw_d    = bw_n;
            end else begin
                phase_d = PH_IDLE;
            end
        end else begin
            unique case (phase_q)
                PH_IDLE: phase_d = PH_IDLE;
                PH_READ, PH_WRITE: begin
                    cnt_d = cnt_q + {{(BURST_W-1){1'b0}}, 1'b1};
                    bw_d  = bw_n;
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    zbt_burst #(.CNT_W(BURST_W)) u_burst (
        .base_low (base_q[BURST_W-1:0]),
        .beat     (cnt_q),
        .linear   (lin_q),
        .low      (low)
    );

    // output process
    always_comb begin
        phase    = phase_q;
        cur_addr = {base_q[ADDR_W-1:BURST_W], low};
        cur_bw_n = bw_q;
    end

    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(phase_q) && $stable(base_q) && $stable(cnt_q));

    p_deselect_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !selected) |=> phase_q == PH_IDLE);

    p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv_ld && !sleep && phase_q != PH_IDLE)
        |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)) && $stable(base_q));

    p_sleep_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && sleep) |=> phase_q == PH_IDLE);

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = cur_addr[ADDR_W-1:BURST_W];
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [LANES-1:0]        lane_n,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !lane_n[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv_ld,
    input  logic                    rd_wr,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_lin,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    phase_e             phase;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LANES-1:0]   cur_bw_n;
    logic               we;

    zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .adv_ld    (adv_ld),
        .rd_wr     (rd_wr),
        .bw_n      (bw_n),
        .burst_lin (burst_lin),
        .sleep     (sleep),
        .addr      (addr),
        .phase     (phase),
        .cur_addr  (cur_addr),
        .cur_bw_n  (cur_bw_n)
    );

    // a pending write completes at the next active edge, selected or not
    assign we = !cke_n && rst_n && (phase == PH_WRITE);

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk    (clk),
        .we     (we),
        .lane_n (cur_bw_n),
        .waddr  (cur_addr),
        .wdata  (din),
        .raddr  (cur_addr),
        .rdata  (dout)
    );

    assign dout_en = (phase == PH_READ) && !oe_n && !sleep;

    always_comb begin
        if (oe_n) p_oe_force_r7: assert (!dout_en);
        if (sleep) p_sleep_off_r10: assert (!dout_en);
    end

    p_write_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && !rd_wr) |=> !dout_en);

    p_deselect_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv_ld && (ce1_n || !ce2 || ce3_n)) |=> !dout_en);
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
    localparam int PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 36;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke_n, ce1_n, ce2, ce3_n, adv_ld, rd_wr, burst_lin, oe_n, sleep;
    logic [3:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    logic dout_en;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string tag = "R11";

    // bench reference model
    logic [DW-1:0] mref [64];
    int m_phase = 0;               // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;
    logic m_lin = 1'b0;
    logic [3:0] m_bw = '1;
    logic [AW-1:0] m_addr = '0;

    zbt_sram i_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld(adv_ld), .rd_wr(rd_wr), .bw_n(bw_n),
        .burst_lin(burst_lin), .oe_n(oe_n), .sleep(sleep), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(int a);
        return 36'h9_3C00_0000 ^ (36'(a) * 36'h0_0101_0107);
    endfunction

    function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] b, logic [1:0] k, logic lin);
        logic [1:0] lo;
        lo = lin ? 2'(b[1:0] + k) : (b[1:0] ^ k);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(bit ok, string t, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic idle_in();
        cke_n = 0; adv_ld = 0; ce1_n = 1; ce2 = 1; ce3_n = 0;
        sleep = 0; oe_n = 0; rd_wr = 1; bw_n = 4'h0; burst_lin = 1; addr = '0;
    endtask

    task automatic cmd(logic rw, int a, logic lin, logic [3:0] bw);
        adv_ld = 0; ce1_n = 0; ce2 = 1; ce3_n = 0;
        rd_wr = rw; addr = AW'(a); burst_lin = lin; bw_n = bw;
    endtask

    task automatic model_edge();
        if (!cke_n) begin
            if (m_phase == 2)
                for (int l = 0; l < 4; l++)
                    if (!m_bw[l]) mref[m_addr][9*l +: 9] = din[9*l +: 9];
            if (sleep) m_phase = 0;
            else if (!adv_ld) begin
                if (!ce1_n && ce2 && !ce3_n) begin
                    m_phase = rd_wr ? 1 : 2;
                    m_base = addr; m_cnt = 0; m_lin = burst_lin; m_bw = bw_n;
                end else m_phase = 0;
            end else if (m_phase != 0) begin
                m_cnt = m_cnt + 2'd1; m_bw = bw_n;
            end
            m_addr = burst_addr(m_base, m_cnt, m_lin);
        end
    endtask

    // one cycle: inputs already set after the falling edge
    task automatic cyc(bit xchk = 0, logic [DW-1:0] xw = '0, string xt = "");
        bit exp_en;
        #1;
        exp_en = (m_phase == 1) && !oe_n && !sleep;
        check(dout_en === exp_en, tag, {35'd0, dout_en}, {35'd0, exp_en});
        if (exp_en) check(dout === mref[m_addr], tag, dout, mref[m_addr]);
        if (xchk) check(dout_en === 1'b1 && dout === xw, xt, dout, xw);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wr_din();
        din = (m_phase == 2) ? pat(int'(m_addr)) : '0;
    endtask

    initial begin
        #(PERIOD*200000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] e;
        void'($urandom(32'd1234));
        idle_in(); din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: idle after reset
        tag = "R11";
        cyc();

        // R2 / R8: fill whole array with linear write bursts
        tag = "R8";
        for (int b = 0; b < 16; b++) begin
            cmd(0, b*4, 1, 4'h0); wr_din(); cyc();
            for (int k = 0; k < 3; k++) begin adv_ld = 1; wr_din(); cyc(); end
        end
        idle_in(); wr_din(); cyc();

        // R8: interleaved burst from base 5 -> 5,4,7,6
        cmd(1, 5, 0, 4'hF); cyc();
        adv_ld = 1; cyc(1, pat(5), "R8");
        cyc(1, pat(4), "R8");
        cyc(1, pat(7), "R8");
        idle_in(); cyc(1, pat(6), "R8");
        // R8: linear burst from base 6 -> 6,7,4,5, wraps to 6
        cmd(1, 6, 1, 4'hF); cyc();
        adv_ld = 1; cyc(1, pat(6), "R8");
        cyc(1, pat(7), "R8");
        cyc(1, pat(4), "R8");
        cyc(1, pat(5), "R8");
        idle_in(); cyc(1, pat(6), "R8");
        // R8: advance while idle stays idle
        adv_ld = 1; cyc(); cyc();

        // R9: write, read, write, read with no gap
        tag = "R9";
        cmd(0, 9, 1, 4'h0); cyc();
        cmd(1, 9, 1, 4'h0); din = 36'hA_BCDE_1234; cyc();
        cmd(0, 12, 1, 4'h0); cyc(1, 36'hA_BCDE_1234, "R9");
        cmd(1, 12, 1, 4'h0); din = 36'h1_1111_2222; cyc();
        idle_in(); ce2 = 0; cyc(1, 36'h1_1111_2222, "R9");
        tag = "R6"; cyc();

        // R2: lanes 0 and 2 written, 1 and 3 kept
        tag = "R2";
        cmd(0, 10, 1, 4'b1010); cyc();
        cmd(1, 10, 1, 4'h0); din = 36'hF_FFFF_FFFF; cyc();
        e = pat(10); e[8:0] = 9'h1FF; e[26:18] = 9'h1FF;
        idle_in(); cyc(1, e, "R2");

        // R3: stall during read phase and during write phase
        tag = "R3";
        cmd(1, 3, 1, 4'h0); cyc();
        cke_n = 1; cyc(1, pat(3), "R3"); cyc(1, pat(3), "R3");
        cke_n = 0; cmd(0, 20, 1, 4'h0); cyc(1, pat(3), "R3");
        cke_n = 1; din = 36'h0_DEAD_0000; cyc();
        cke_n = 0; cmd(1, 20, 1, 4'h0); din = 36'h5_5555_AAAA; cyc();
        idle_in(); cyc(1, 36'h5_5555_AAAA, "R3");

        // R5 / R6: pending read and write finish despite deselect
        tag = "R5";
        cmd(1, 33, 1, 4'h0); cyc();
        idle_in(); ce3_n = 1; cyc(1, pat(33), "R5");
        tag = "R6"; cyc();
        tag = "R5";
        cmd(0, 34, 1, 4'h0); cyc();
        idle_in(); din = 36'h3_0303_0303; cyc();
        cmd(1, 34, 1, 4'h0); cyc();
        idle_in(); cyc(1, 36'h3_0303_0303, "R5");
        tag = "R6";
        cmd(0, 35, 1, 4'h0); cyc();
        idle_in(); din = 36'h0; cyc();

        // R7: output enable forces off in a read phase
        tag = "R7";
        cmd(1, 40, 1, 4'h0); cyc();
        idle_in(); oe_n = 1; cyc();
        // R10: sleep blocks a load and an advance
        tag = "R10";
        cmd(1, 41, 1, 4'h0); sleep = 1; cyc();
        sleep = 0; idle_in(); cyc();
        cmd(1, 42, 1, 4'h0); cyc();
        adv_ld = 1; sleep = 1; cyc();
        sleep = 0; cyc();

        // R1 / R4: constrained random stream
        tag = "R1";
        for (int i = 0; i < 4000; i++) begin
            cke_n = ($urandom_range(9) == 0);
            adv_ld = ($urandom_range(9) < 3);
            ce1_n = ($urandom_range(19) == 0);
            ce2 = ($urandom_range(19) != 0);
            ce3_n = ($urandom_range(19) == 0);
            rd_wr = $urandom_range(1);
            bw_n = 4'($urandom_range(15));
            burst_lin = $urandom_range(1);
            oe_n = ($urandom_range(9) == 0);
            sleep = ($urandom_range(29) == 0);
            addr = AW'($urandom_range(63));
            din = {4'($urandom_range(15)), 32'($urandom)};
            cyc();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule